// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM with a four-beat burst counter, byte-granular writes and a registered read path. The word is eight bytes wide and the depth is set by a parameter. All synchronous inputs are captured on the rising clock edge. A burst starts on either of two active-low address strobes. After that, the block either advances its internal two-bit burst counter or holds the current address. The counter order is linear or interleaved, chosen by a level input.

Read data leaves through a two-stage registered path. The first stage is the array read register and the second is the output register. Separate write-data and read-data ports replace a shared bus. A valid flag stands in for the high-impedance state. Output enable and sleep act on that flag without waiting for a clock. While the sleep input is high, the array keeps its contents and accepts no access. When sleep is released, a two-cycle window follows in which strobes are refused. A strobe in that window raises a sticky error flag.

Top module: `pipe_burst_sram`

## Requirements
- R1: While reset is active and after it is released, rvalid_o is 0, rdata_o is 0 and wake_err_o is 0 until a read reaches the output.
- R2: When gw_n is 0 in a write cycle, all eight bytes of the addressed word take wdata_i, whatever bwe_n and bw_n are.
- R3: When gw_n is 1 and bwe_n is 0, byte b (bits 8b+7:8b) is written only if bw_n[b] is 0, and the other bytes keep their contents. When gw_n is 1 and either bwe_n is 1 or bw_n is all ones, the cycle is a read.
- R4: An accepted proc_strobe_n edge always reads addr_i, even when write inputs are active. A write on the next edge, with no strobe and adv_n at 1, goes to that same address.
- R5: An accepted ctrl_strobe_n edge writes addr_i when a write enable is active and reads it otherwise.
- R6: The chip enables (ce_n low, ce_hi high, ce_lo_n low) are evaluated only on strobe edges. If any of them is inactive there, the block is deselected and makes no access until the next strobe. proc_strobe_n is ignored while ce_n is 1. Enable changes between strobes have no effect.
- R7: On each non-strobe edge of a selected burst, adv_n at 0 advances a two-bit counter n before the access. The low two address bits are then (a+n) mod 4 when linear_i is 1, or a XOR n when linear_i is 0, and the upper bits are unchanged. adv_n at 1 repeats the current address.
- R8: Read data for an access made at edge k is present on rdata_o, with rvalid_o at 1, after edge k+1 and before edge k+2.
- R9: oe_n at 1 forces rvalid_o and rdata_o to 0 at once. A read result whose output slot follows a write edge is dropped.
- R10: While sleep_i is 1, rvalid_o is 0 at once, no edge makes an access, the burst selection is cleared and stored data is retained.
- R11: The first two edges after sleep_i falls refuse both strobes. A strobe on either edge sets wake_err_o, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address captured on strobe edges |
| proc_strobe_n | input | 1 | Processor-side address strobe, starts a read |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, starts a read or a write |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low; also gates proc_strobe_n |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| gw_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | NBYTES | Per-byte write selects, active low |
| wdata_i | input | NBYTES*BYTE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request with data retention |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata_o | output | NBYTES*BYTE_W | Read data, 0 when not valid |
| rvalid_o | output | 1 | Read data valid and driven |
| wake_err_o | output | 1 | Sticky flag for a strobe during wake-up lockout |

## Verification
Most state in this block shows up at the ports one or two edges after it goes wrong. A wrong burst counter or base address returns another word's data on the read that follows. A wrong lockout counter either lets a strobe through inside the window or refuses one after it, and the bench sees this in the next data slot and in wake_err_o. A write that corrupts a byte it should not touch stays hidden until that word is read again. For that reason, the reference model is compared on every edge across a long mix of partial writes and bursts over a small address range.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  localparam int unsigned BURST_CW = 2;

endpackage

// File: rtl/byte_write_decode.sv
module byte_write_decode #(
  parameter int unsigned NBYTES = 8
) (
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bw_n,
  output logic [NBYTES-1:0] mask_o,
  output logic              any_o
);

  // Whole-word write overrides the per-byte path.
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign mask_o[b] = !gw_n || (!bwe_n && !bw_n[b]);
  end

  assign any_o = |mask_o;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_burst_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          linear_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0]       base_q, base_d;
  logic [BURST_CW-1:0] cnt_q, cnt_d;
  logic [BURST_CW-1:0] step;
  logic [BURST_CW-1:0] lo_seq;

  always_comb begin
    step   = cnt_q + BURST_CW'(adv_i);
    lo_seq = linear_i ? (base_q[BURST_CW-1:0] + step)
                      : (base_q[BURST_CW-1:0] ^ step);
    addr_o = load_i ? addr_i : {base_q[AW-1:BURST_CW], lo_seq};
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      base_d = addr_i;
      cnt_d  = '0;
    end else if (adv_i) begin
      cnt_d  = step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R7: a hold cycle right after a load addresses the loaded word
  a_r7_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i ##1 (!load_i && !adv_i)) |-> (addr_o == $past(addr_i)));

  // R7: a hold cycle after an advance repeats the advanced address
  a_r7_suspend_repeats: assert property (@(posedge clk) disable iff (!rst_n)
    ((!load_i && adv_i) ##1 (!load_i && !adv_i)) |-> (addr_o == $past(addr_o)));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned AW     = 8,
  parameter int unsigned NBYTES = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBYTES-1:0]        we_i,
  input  logic                     re_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);

  localparam int unsigned DW    = NBYTES * BYTE_W;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [DW-1:0] wr_bits;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bits
    assign wr_bits[b*BYTE_W +: BYTE_W] = {BYTE_W{we_i[b]}};
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBYTES; b++) begin
      if (we_i[b]) mem[addr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
    if (re_i) rd_q <= mem[addr_i];
  end

  assign rdata_o = rd_q;

  // R3: bytes outside the write mask keep their old value
  a_r3_unwritten_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|we_i) |=> (((mem[$past(addr_i)] ^ $past(mem[addr_i])) & ~$past(wr_bits)) == '0));

  // R2: bytes inside the write mask take the write data
  a_r2_written_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (|we_i) |=> (((mem[$past(addr_i)] ^ $past(wdata_i)) & $past(wr_bits)) == '0));

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import sram_burst_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned NBYTES  = 8,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned REC_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr_i,
  input  logic                     proc_strobe_n,
  input  logic                     ctrl_strobe_n,
  input  logic                     adv_n,
  input  logic                     ce_n,
  input  logic                     ce_hi,
  input  logic                     ce_lo_n,
  input  logic                     gw_n,
  input  logic                     bwe_n,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic                     oe_n,
  input  logic                     sleep_i,
  input  logic                     linear_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o,
  output logic                     rvalid_o,
  output logic                     wake_err_o
);

  localparam int unsigned DW  = NBYTES * BYTE_W;
  localparam int unsigned RCW = $clog2(REC_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [NBYTES-1:0] wmask;
  logic              wr_req;
  logic [AW-1:0]     acc_addr;
  logic [DW-1:0]     arr_rdata;

  logic           sel_q, sel_d;
  logic [RCW-1:0] rec_q, rec_d;
  logic           err_q, err_d;
  logic           v1_q, v1_d;
  logic           ov_q, ov_d;
  logic [DW-1:0]  od_q;

  logic     strobe_any, locked, active;
  logic     proc_go, ctrl_go, start, en_all, cont, load, adv;
  sram_op_e op;
  logic     re;
  logic [NBYTES-1:0] we;

  byte_write_decode #(.NBYTES(NBYTES)) u_bwd (
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bw_n   (bw_n),
    .mask_o (wmask),
    .any_o  (wr_req)
  );

  always_comb begin
    strobe_any = !proc_strobe_n || !ctrl_strobe_n;
    locked     = (rec_q != '0);
    active     = !sleep_i && !locked;
    proc_go    = active && !proc_strobe_n && !ce_n;
    ctrl_go    = active && !proc_go && !ctrl_strobe_n;
    start      = proc_go || ctrl_go;
    en_all     = !ce_n && ce_hi && !ce_lo_n;
    load       = start && en_all;
    cont       = active && !start && sel_q;
    adv        = cont && !adv_n;

    op = OP_NONE;
    if (load) begin
      op = (proc_go || !wr_req) ? OP_READ : OP_WRITE;
    end else if (cont) begin
      op = wr_req ? OP_WRITE : OP_READ;
    end
    re = (op == OP_READ);
    we = (op == OP_WRITE) ? wmask : '0;

    sel_d = sel_q;
    if (sleep_i)    sel_d = 1'b0;
    else if (start) sel_d = en_all;

    rec_d = rec_q;
    if (sleep_i)     rec_d = RCW'(REC_CYC);
    else if (locked) rec_d = rec_q - RCW'(1);

    err_d = err_q || (!sleep_i && locked && strobe_any);
    v1_d  = re;
    ov_d  = v1_q && (op != OP_WRITE) && !sleep_i;
  end

  burst_addr_gen #(.AW(AW)) u_bag (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .load_i   (load),
    .adv_i    (adv),
    .linear_i (linear_i),
    .addr_i   (addr_i),
    .addr_o   (acc_addr)
  );

  sram_array #(.AW(AW), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .we_i    (we),
    .re_i    (re),
    .addr_i  (acc_addr),
    .wdata_i (wdata_i),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      sel_q <= 1'b0;
      rec_q <= '0;
      err_q <= 1'b0;
      v1_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      rec_q <= rec_d;
      err_q <= err_d;
      v1_q  <= v1_d;
      ov_q  <= ov_d;
    end
  end

  always_ff @(posedge clk) begin
    if (v1_q) od_q <= arr_rdata;
  end

  assign rvalid_o   = ov_q && !oe_n && !sleep_i;
  assign rdata_o    = rvalid_o ? od_q : '0;
  assign wake_err_o = err_q;

  // R11: a strobe inside the lockout window raises the flag
  a_r11_err_on_locked_strobe: assert property (@(posedge clk) disable iff (!rst_s_q)
    (locked && !sleep_i && strobe_any) |=> wake_err_o);

  // R11: the flag never clears outside reset
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_s_q)
    wake_err_o |=> wake_err_o);

  // R8: valid output always comes from a read issued two edges earlier
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_s_q)
    rvalid_o |-> $past(re, 2));

  // R10: no access is made on an edge that sees sleep
  a_r10_sleep_no_select: assert property (@(posedge clk) disable iff (!rst_s_q)
    sleep_i |=> !sel_q && !v1_q);

endmodule

// File: tb/tb_pipe_burst_sram.sv
module tb_pipe_burst_sram;

  localparam int AW = 8;
  localparam int NB = 8;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          proc_strobe_n, ctrl_strobe_n, adv_n;
  logic          ce_n, ce_hi, ce_lo_n;
  logic          gw_n, bwe_n;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] wdata_i;
  logic          oe_n, sleep_i, linear_i;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o, wake_err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pipe_burst_sram #(.AW(AW), .NBYTES(NB), .BYTE_W(8), .REC_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
    .ce_n(ce_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .wdata_i(wdata_i),
    .oe_n(oe_n), .sleep_i(sleep_i), .linear_i(linear_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .wake_err_o(wake_err_o)
  );

  // reference model state
  logic [63:0] mmem [int];
  bit          msel;
  logic [7:0]  mbase;
  int          mcnt, mrec;
  bit          merr;
  bit          p1v, ov;
  logic [63:0] p1d, od;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [63:0] mask;
    bit pgo, cgo, start, enall, cont, wr;
    int op, a, lo;
    for (int b = 0; b < NB; b++)
      mask[b*8 +: 8] = {8{(!gw_n) || (!bwe_n && !bw_n[b])}};
    wr = (mask != 0);
    op = 0;
    a  = 0;
    if (sleep_i) begin
      mrec = 2;
      msel = 0;
    end else if (mrec != 0) begin
      mrec--;
      if (!proc_strobe_n || !ctrl_strobe_n) merr = 1;
    end else begin
      pgo   = !proc_strobe_n && !ce_n;
      cgo   = !pgo && !ctrl_strobe_n;
      start = pgo || cgo;
      enall = !ce_n && ce_hi && !ce_lo_n;
      cont  = !start && msel;
      if (start) begin
        msel = enall;
        if (enall) begin
          mbase = addr_i;
          mcnt  = 0;
          a     = addr_i;
          op    = (pgo || !wr) ? 1 : 2;
        end
      end else if (cont) begin
        if (!adv_n) mcnt = (mcnt + 1) % 4;
        lo = linear_i ? ((mbase[1:0] + mcnt) % 4) : (mbase[1:0] ^ mcnt);
        a  = {mbase[7:2], 2'(lo)};
        op = wr ? 2 : 1;
      end
    end
    ov = p1v && (op != 2) && !sleep_i;
    od = p1d;
    p1v = (op == 1);
    if (op == 1) p1d = mmem[a];
    if (op == 2) mmem[a] = (mmem[a] & ~mask) | (wdata_i & mask);
  endtask

  task automatic compare(input string tag);
    bit ev;
    ev = ov && !oe_n && !sleep_i;
    chk(rvalid_o == ev, {tag, " rvalid"}, 64'(rvalid_o), 64'(ev));
    chk(rdata_o == (ev ? od : 64'h0), {tag, " rdata"}, rdata_o, ev ? od : 64'h0);
    chk(wake_err_o == merr, {tag, " wake_err R11"}, 64'(wake_err_o), 64'(merr));
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    addr_i = '0; proc_strobe_n = 1; ctrl_strobe_n = 1; adv_n = 1;
    ce_n = 0; ce_hi = 1; ce_lo_n = 0; gw_n = 1; bwe_n = 1; bw_n = '1;
    wdata_i = '0;
  endtask

  task automatic ctrl_write(input int a, input logic [63:0] d, input string tag);
    idle(); ctrl_strobe_n = 0; addr_i = 8'(a); gw_n = 0; wdata_i = d;
    step(tag);
  endtask

  task automatic ctrl_read(input int a, input string tag);
    idle(); ctrl_strobe_n = 0; addr_i = 8'(a);
    step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); oe_n = 0; sleep_i = 0; linear_i = 1;
    msel = 0; mbase = 0; mcnt = 0; mrec = 0; merr = 0;
    p1v = 0; ov = 0; p1d = 0; od = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(rvalid_o == 0 && rdata_o == 0, "R1 reset outputs", rdata_o, 64'h0);
    chk(wake_err_o == 0, "R1 reset flag", 64'(wake_err_o), 64'h0);
    rst_n = 1;
    repeat (4) step("R1 after reset");

    // fill words 0..31 with whole-word writes
    for (int a = 0; a < 32; a++) ctrl_write(a, {$urandom(), $urandom()}, "R2 fill");
    step("R2 idle");

    // R4: processor strobe reads even with gw_n low, then write on the next edge
    idle(); proc_strobe_n = 0; addr_i = 3; gw_n = 0; wdata_i = 64'h1111_2222_3333_4444;
    step("R4 proc strobe read");
    idle(); gw_n = 0; wdata_i = 64'hDEAD_BEEF_0123_4567;
    step("R4 follow-up write");
    idle(); step("R9 read dropped after write");
    ctrl_read(3, "R4 readback");
    idle(); step("R8 one-clock pipeline");
    idle(); step("R8 data slot");

    // R3: partial byte write and bwe_n high making a read
    idle(); ctrl_strobe_n = 0; addr_i = 7; bwe_n = 0; bw_n = 8'b1010_0110;
    wdata_i = 64'hA1B2_C3D4_E5F6_0718;
    step("R3 byte write");
    idle(); ctrl_strobe_n = 0; addr_i = 7; bwe_n = 1; bw_n = 8'h00;
    step("R3 bwe high is read");
    idle(); step("R3 wait");
    idle(); step("R3 readback data");

    // R5: controller strobe write then read
    ctrl_write(12, 64'h0F0F_F0F0_AAAA_5555, "R5 ctrl write");
    ctrl_read(12, "R5 ctrl read");
    idle(); step("R5 wait");
    idle(); step("R5 data");

    // R7: linear burst with suspend and wrap
    linear_i = 1;
    ctrl_read(9, "R7 linear start");
    for (int i = 0; i < 3; i++) begin idle(); adv_n = 0; step("R7 linear advance"); end
    idle(); adv_n = 1; step("R7 suspend");
    idle(); adv_n = 0; step("R7 linear wrap");
    idle(); step("R7 tail");
    // R7: interleaved burst
    linear_i = 0;
    ctrl_read(14, "R7 interleave start");
    for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; step("R7 interleave advance"); end
    idle(); step("R7 tail2");
    linear_i = 1;
    // burst write
    ctrl_write(16, 64'h1, "R7 burst write start");
    for (int i = 0; i < 3; i++) begin idle(); adv_n = 0; gw_n = 0; wdata_i = 64'(i + 2); step("R7 burst write"); end
    ctrl_read(17, "R7 burst write check");
    idle(); step("R7 wait"); idle(); step("R7 data");

    // R6: deselect and enable masking
    idle(); ctrl_strobe_n = 0; addr_i = 20; ce_hi = 0; step("R6 deselect");
    for (int i = 0; i < 3; i++) begin idle(); adv_n = 0; step("R6 no access while deselected"); end
    ctrl_read(20, "R6 start burst");
    idle(); proc_strobe_n = 0; ce_n = 1; addr_i = 25; adv_n = 0; step("R6 proc strobe masked");
    idle(); ce_hi = 0; ce_lo_n = 1; adv_n = 0; step("R6 enables ignored between strobes");
    idle(); step("R6 tail"); idle(); step("R6 tail2");

    // R9: output enable, checked before and after the change
    ctrl_read(5, "R9 read");
    idle(); step("R9 wait");
    chk(rvalid_o == 1, "R9 valid before oe", 64'(rvalid_o), 64'h1);
    oe_n = 1; #1;
    chk(rvalid_o == 0 && rdata_o == 0, "R9 oe high gates output", rdata_o, 64'h0);
    oe_n = 0; idle(); step("R9 after");

    // R10: sleep gating, no access, retention
    ctrl_read(6, "R10 read");
    idle(); step("R10 wait");
    sleep_i = 1; #1;
    chk(rvalid_o == 0, "R10 sleep gates output", 64'(rvalid_o), 64'h0);
    idle(); ctrl_strobe_n = 0; addr_i = 6; gw_n = 0; wdata_i = '1;
    step("R10 write ignored in sleep");
    idle(); proc_strobe_n = 0; addr_i = 6; step("R10 read ignored in sleep");
    sleep_i = 0;
    // R11: lockout edges
    idle(); step("R11 lock edge 1 quiet");
    chk(wake_err_o == 0, "R11 no flag without strobe", 64'(wake_err_o), 64'h0);
    idle(); proc_strobe_n = 0; addr_i = 6; step("R11 lock edge 2 strobe");
    chk(wake_err_o == 1, "R11 flag set", 64'(wake_err_o), 64'h1);
    ctrl_read(6, "R10 retention read");
    idle(); step("R10 wait2"); idle(); step("R10 retained data");

    // mixed random traffic
    for (int n = 0; n < 800; n++) begin
      int r;
      r = $urandom % 100;
      idle();
      proc_strobe_n = !(r < 12);
      ctrl_strobe_n = !(r >= 12 && r < 26);
      adv_n   = 1'($urandom % 2);
      ce_n    = ($urandom % 10 == 0);
      ce_hi   = ($urandom % 10 != 0);
      ce_lo_n = ($urandom % 12 == 0);
      gw_n    = ($urandom % 4 != 0);
      bwe_n   = 1'($urandom % 2);
      bw_n    = 8'($urandom);
      wdata_i = {$urandom(), $urandom()};
      addr_i  = 8'($urandom % 32);
      oe_n    = ($urandom % 8 == 0);
      sleep_i = ($urandom % 40 == 0);
      if ($urandom % 50 == 0) linear_i = !linear_i;
      step("mixed R2 R3 R7 R9 R10");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule